// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a two-bit address. Addresses 0, 1 and 2 are the count ports of channels 0, 1 and 2, and address 3 is the control port. A control byte does one of three things. It programs a channel's byte-access order, counting mode and BCD flag. It freezes a channel's running count. Or it issues a read-back command that can freeze the count and/or a status byte for any subset of the channels in one write.

The counting logic sits in separate per-channel counters, outside this block. This block feeds each counter a one-cycle load strobe with a 16-bit load value, and the counter's mode and BCD setting. In return it samples each counter's live count and OUT level. The host can read the live count, a frozen count or a frozen status byte, one byte per read, in the byte order the channel was programmed for.

Top module: `tmr_host_if`

## Requirements
- R1: A write to address 3 with bits 7:6 equal to 0, 1 or 2 and bits 5:4 non-zero programs that channel. Bits 5:4 set the access order (1 = low byte only, 2 = high byte only, 3 = low byte then high byte), bits 3:1 set the counting mode and bit 0 sets BCD. `chan_mode` and `chan_bcd` show the new values one cycle after the write.
- R2: Mode codes 6 and 7 are stored as 2 and 3. The stored mode never exceeds 5.
- R3: A count-port write in low-only order loads {8'h00, data}. In high-only order it loads {data, 8'h00}. The channel's `load_stb` is high for exactly the one cycle after the write, with `load_value` valid in that cycle.
- R4: In low-then-high order, the first count-port write only buffers the byte and gives no strobe. The second write loads {second, first}.
- R5: With nothing latched, a count-port read returns the live count. Low-only order gives the low byte, high-only order gives the high byte, and low-then-high order alternates low and high, starting with low.
- R6: A control write with bits 5:4 = 0 freezes the selected channel's live count as sampled in the write cycle. Later reads return the frozen bytes in the channel's access order. In low-then-high order they return low, then high, then release the freeze.
- R7: A count-latch or status-latch request for a channel that already holds an unread value of that kind leaves the held value unchanged.
- R8: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes the count and bit 4 low freezes the status, on every selected channel at once.
- R9: The status byte is {OUT, 0, access[1:0], mode[2:0], BCD}, with OUT sampled in the command cycle. A held status is returned before any held count, and one read clears it.
- R10: Programming a channel returns both its read and write byte toggles to the low byte.
- R11: A read of address 3 returns 0, and `host_rdata` is 0 whenever `host_rd` is low.
- R12: After reset every channel uses low-then-high order, mode 0 and binary counting, with no held values and no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| host_addr | input | 2 | Register address: 0..2 count ports, 3 control port |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address and state |
| live_count | input | 48 | Running count of each channel, channel i at bits 16i+15:16i |
| live_out | input | 3 | OUT level of each channel |
| load_stb | output | 3 | One-cycle load request per channel |
| load_value | output | 48 | Load value per channel, same packing as live_count |
| chan_mode | output | 9 | Counting mode per channel, 3 bits each |
| chan_bcd | output | 3 | BCD flag per channel |

## Verification
Directed sequences come first. They cover each access order on loads and live reads, mode folding, a frozen count that must not follow a changing live count, a repeated latch that must not overwrite, and a read-back that freezes status and count together so that the status must come out first. A half-finished two-byte transfer followed by reprogramming shows whether the toggles restart. A seeded random mix of control bytes, count writes, reads of all four addresses and changing live inputs then runs against a reference model in the bench. That mix exposes ordering faults between held status, held count and the live toggle that the fixed cases might miss.

// File: rtl/tmr_hif_pkg.sv
package tmr_hif_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 2 * BYTE_W;
    localparam int unsigned MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wtog;
        logic              rtog;
        logic [BYTE_W-1:0] wlo;
        acc_e              lat_acc;
        logic [CNT_W-1:0]  lat_cnt;
        logic              sts_vld;
        logic [BYTE_W-1:0] sts;
        logic              ld_stb;
        logic [CNT_W-1:0]  ld_val;
    } chan_st_t;

    function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
        return (m > 3'd5) ? m - 3'd4 : m;
    endfunction
endpackage

// File: rtl/tmr_hif_decode.sv
module tmr_hif_decode
    import tmr_hif_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [NUM_CH-1:0]     prog,
    output logic [NUM_CH-1:0]     lat_cnt,
    output logic [NUM_CH-1:0]     lat_sts,
    output logic [NUM_CH-1:0]     data_wr,
    output acc_e                  prog_acc,
    output logic [MODE_W-1:0]     prog_mode,
    output logic                  prog_bcd
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL    = 2'd3;

    logic       ctrl_wr;
    logic [1:0] sel;
    logic       is_rb;

    assign ctrl_wr   = wr_en && (addr == CTRL_ADDR);
    assign sel       = wdata[7:6];
    assign is_rb     = ctrl_wr && (sel == RB_SEL);
    assign prog_acc  = acc_e'(wdata[5:4]);
    assign prog_mode = fold_mode(wdata[3:1]);
    assign prog_bcd  = wdata[0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit        = ctrl_wr && (sel == 2'(i));
        assign prog[i]    = hit && (prog_acc != ACC_LATCH);
        assign lat_cnt[i] = (hit && (prog_acc == ACC_LATCH))
                          || (is_rb && wdata[i+1] && !wdata[5]);
        assign lat_sts[i] = is_rb && wdata[i+1] && !wdata[4];
        assign data_wr[i] = wr_en && (addr == 2'(i));
    end
endmodule

// File: rtl/tmr_hif_chan.sv
module tmr_hif_chan
    import tmr_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  acc_e              prog_acc,
    input  logic [MODE_W-1:0] prog_mode,
    input  logic              prog_bcd,
    input  logic              lat_cnt_i,
    input  logic              lat_sts_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_i,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              live_out,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ld_stb = 1'b0;
        if (prog_i) begin
            st_d.acc  = prog_acc;
            st_d.mode = prog_mode;
            st_d.bcd  = prog_bcd;
            st_d.wtog = 1'b0;
            st_d.rtog = 1'b0;
        end
        if (lat_cnt_i && (st_q.lat_acc == ACC_LATCH)) begin
            st_d.lat_acc = st_q.acc;
            st_d.lat_cnt = live_cnt;
        end
        if (lat_sts_i && !st_q.sts_vld) begin
            st_d.sts_vld = 1'b1;
            st_d.sts     = {live_out, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
        end
        if (wr_i) begin
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.ld_stb = 1'b1;
                    st_d.ld_val = {8'h00, wdata};
                end
                ACC_HI: begin
                    st_d.ld_stb = 1'b1;
                    st_d.ld_val = {wdata, 8'h00};
                end
                ACC_WORD: begin
                    if (!st_q.wtog) begin
                        st_d.wlo  = wdata;
                        st_d.wtog = 1'b1;
                    end else begin
                        st_d.ld_stb = 1'b1;
                        st_d.ld_val = {wdata, st_q.wlo};
                        st_d.wtog   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (rd_i) begin
            if (st_q.sts_vld) begin
                st_d.sts_vld = 1'b0;
            end else if (st_q.lat_acc != ACC_LATCH) begin
                st_d.lat_acc = (st_q.lat_acc == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rtog = ~st_q.rtog;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.acc     <= ACC_WORD;
            st_q.lat_acc <= ACC_LATCH;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.sts_vld) begin
            rd_byte = st_q.sts;
        end else if (st_q.lat_acc != ACC_LATCH) begin
            rd_byte = (st_q.lat_acc == ACC_HI) ? st_q.lat_cnt[CNT_W-1:BYTE_W]
                                               : st_q.lat_cnt[BYTE_W-1:0];
        end else if ((st_q.acc == ACC_HI) || ((st_q.acc == ACC_WORD) && st_q.rtog)) begin
            rd_byte = live_cnt[CNT_W-1:BYTE_W];
        end else begin
            rd_byte = live_cnt[BYTE_W-1:0];
        end
    end

    assign ld_stb = st_q.ld_stb;
    assign ld_val = st_q.ld_val;
    assign mode   = st_q.mode;
    assign bcd    = st_q.bcd;

    // R3: a strobe only ever follows a count-port write
    p_stb_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ld_stb |-> $past(wr_i));
    // R4: the first byte of a two-byte load gives no strobe
    p_word_first_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && st_q.acc == ACC_WORD && !st_q.wtog) |=> !st_q.ld_stb);
    // R2: folded mode stays in the legal range
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode <= 3'd5);
    // R7: a held count is not overwritten until read
    p_latch_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat_acc != ACC_LATCH && !rd_i) |=> $stable(st_q.lat_cnt));
    // R9: status leaves first and leaves the held count untouched
    p_status_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_q.sts_vld) |=> (!st_q.sts_vld && $stable(st_q.lat_acc)));
    // R10: programming restarts both toggles
    p_prog_resets_toggles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> (!st_q.rtog && !st_q.wtog));
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_hif_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                host_addr,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    input  logic [NUM_CH*16-1:0]      live_count,
    input  logic [NUM_CH-1:0]         live_out,
    output logic [NUM_CH-1:0]         load_stb,
    output logic [NUM_CH*16-1:0]      load_value,
    output logic [NUM_CH*3-1:0]       chan_mode,
    output logic [NUM_CH-1:0]         chan_bcd
);
    logic [NUM_CH-1:0] prog, lat_cnt, lat_sts, data_wr;
    acc_e              prog_acc;
    logic [MODE_W-1:0] prog_mode;
    logic              prog_bcd;
    logic [BYTE_W-1:0] ch_byte [NUM_CH];

    tmr_hif_decode #(.NUM_CH(NUM_CH)) dec_i (
        .wr_en     (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .prog      (prog),
        .lat_cnt   (lat_cnt),
        .lat_sts   (lat_sts),
        .data_wr   (data_wr),
        .prog_acc  (prog_acc),
        .prog_mode (prog_mode),
        .prog_bcd  (prog_bcd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        tmr_hif_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog_i    (prog[i]),
            .prog_acc  (prog_acc),
            .prog_mode (prog_mode),
            .prog_bcd  (prog_bcd),
            .lat_cnt_i (lat_cnt[i]),
            .lat_sts_i (lat_sts[i]),
            .wr_i      (data_wr[i]),
            .wdata     (host_wdata),
            .rd_i      (host_rd && (host_addr == 2'(i))),
            .live_cnt  (live_count[i*CNT_W +: CNT_W]),
            .live_out  (live_out[i]),
            .rd_byte   (ch_byte[i]),
            .ld_stb    (load_stb[i]),
            .ld_val    (load_value[i*CNT_W +: CNT_W]),
            .mode      (chan_mode[i*MODE_W +: MODE_W]),
            .bcd       (chan_bcd[i])
        );
    end

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (host_rd && (host_addr == 2'(i))) host_rdata = ch_byte[i];
        end
    end

    // R11: the control port reads as zero
    p_ctrl_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd3) |-> (host_rdata == 8'h00));
    // R12: no strobe in the first cycle out of reset
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> (load_stb == '0));
endmodule

// File: tb/tmr_host_if_tb_top.sv
module tmr_host_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [47:0] live_count;
    logic [2:0]  live_out = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_value;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;

    logic [15:0] lc [3];

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [1:0]  m_acc  [3];
    logic [2:0]  m_mode [3];
    logic        m_bcd  [3];
    logic        m_wt   [3];
    logic        m_rt   [3];
    logic [7:0]  m_wlo  [3];
    logic [1:0]  m_la   [3];
    logic [15:0] m_lc   [3];
    logic        m_sv   [3];
    logic [7:0]  m_sts  [3];

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 3; i++) live_count[i*16 +: 16] = lc[i];
    end

    tmr_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .live_count(live_count), .live_out(live_out), .load_stb(load_stb),
        .load_value(load_value), .chan_mode(chan_mode), .chan_bcd(chan_bcd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] fold(input logic [2:0] m);
        return (m > 3'd5) ? m - 3'd4 : m;
    endfunction

    function automatic logic [7:0] exp_byte(input int ch);
        if (ch == 3) return 8'h00;
        if (m_sv[ch]) return m_sts[ch];
        if (m_la[ch] != 2'd0) return (m_la[ch] == 2'd2) ? m_lc[ch][15:8] : m_lc[ch][7:0];
        if (m_acc[ch] == 2'd2 || (m_acc[ch] == 2'd3 && m_rt[ch])) return lc[ch][15:8];
        return lc[ch][7:0];
    endfunction

    function automatic string rd_tag(input int ch);
        if (ch == 3) return "R11";
        if (m_sv[ch]) return "R9";
        if (m_la[ch] != 2'd0) return "R6";
        return "R5";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_acc[i] = 2'd3; m_mode[i] = '0; m_bcd[i] = 1'b0; m_wt[i] = 1'b0;
            m_rt[i] = 1'b0; m_wlo[i] = '0; m_la[i] = '0; m_lc[i] = '0;
            m_sv[i] = 1'b0; m_sts[i] = '0;
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] v, input string req);
        logic [2:0]  es;
        logic [15:0] ev;
        int          ech;
        es = '0; ev = '0; ech = 0;
        if (a == 2'd3) begin
            if (v[7:6] == 2'd3) begin
                for (int i = 0; i < 3; i++) begin
                    if (v[i+1]) begin
                        if (!v[5] && m_la[i] == 2'd0) begin m_la[i] = m_acc[i]; m_lc[i] = lc[i]; end
                        if (!v[4] && !m_sv[i]) begin
                            m_sv[i] = 1'b1;
                            m_sts[i] = {live_out[i], 1'b0, m_acc[i], m_mode[i], m_bcd[i]};
                        end
                    end
                end
            end else if (v[5:4] == 2'd0) begin
                if (m_la[v[7:6]] == 2'd0) begin m_la[v[7:6]] = m_acc[v[7:6]]; m_lc[v[7:6]] = lc[v[7:6]]; end
            end else begin
                m_acc[v[7:6]] = v[5:4]; m_mode[v[7:6]] = fold(v[3:1]); m_bcd[v[7:6]] = v[0];
                m_wt[v[7:6]] = 1'b0; m_rt[v[7:6]] = 1'b0;
            end
        end else begin
            ech = int'(a);
            case (m_acc[a])
                2'd1: begin es[a] = 1'b1; ev = {8'h00, v}; end
                2'd2: begin es[a] = 1'b1; ev = {v, 8'h00}; end
                default: begin
                    if (!m_wt[a]) begin m_wlo[a] = v; m_wt[a] = 1'b1; end
                    else begin es[a] = 1'b1; ev = {v, m_wlo[a]}; m_wt[a] = 1'b0; end
                end
            endcase
        end
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
        chk(load_stb == es, req, load_stb, es);
        if (es != 0) chk(load_value[ech*16 +: 16] == ev, req, load_value[ech*16 +: 16], ev);
        for (int i = 0; i < 3; i++) begin
            chk(chan_mode[i*3 +: 3] == m_mode[i] && chan_bcd[i] == m_bcd[i], "R1",
                {chan_mode[i*3 +: 3], chan_bcd[i]}, {m_mode[i], m_bcd[i]});
        end
    endtask

    task automatic do_rd(input logic [1:0] a);
        logic [7:0] e;
        string      t;
        e = exp_byte(int'(a));
        t = rd_tag(int'(a));
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 chk(host_rdata == e, t, host_rdata, e);
        @(posedge clk);
        #1 host_rd = 1'b0;
        if (a != 2'd3) begin
            if (m_sv[a]) m_sv[a] = 1'b0;
            else if (m_la[a] != 2'd0) m_la[a] = (m_la[a] == 2'd3) ? 2'd2 : 2'd0;
            else if (m_acc[a] == 2'd3) m_rt[a] = ~m_rt[a];
        end
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        @(negedge clk);
        lc[ch] = v;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        lc[0] = 16'h1357; lc[1] = 16'h2468; lc[2] = 16'hBEEF;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset state
        chk(load_stb == 3'b000, "R12", load_stb, 0);
        chk(chan_mode == 9'd0 && chan_bcd == 3'd0, "R12", chan_mode, 0);
        chk(host_rdata == 8'h00, "R11", host_rdata, 0);
        do_rd(2'd0); do_rd(2'd0);                 // R5 / R12: default word order
        // R1 R3: low-only load, mode 2
        do_wr(2'd3, 8'h14, "R1"); do_wr(2'd0, 8'h5A, "R3");
        do_rd(2'd0); do_rd(2'd0);                 // R5 low byte twice
        // R2 R3: mode 7 folds to 3, high-only load
        do_wr(2'd3, 8'h6E, "R2"); do_wr(2'd1, 8'hA5, "R3");
        do_rd(2'd1);
        // R4: two-byte load with BCD
        do_wr(2'd3, 8'hB1, "R1"); do_wr(2'd2, 8'h34, "R4"); do_wr(2'd2, 8'h12, "R4");
        // R6 R7: latch, live changes, second latch ignored
        do_wr(2'd3, 8'h80, "R6");
        set_live(2, 16'hCAFE);
        do_wr(2'd3, 8'h80, "R7");
        do_rd(2'd2); do_rd(2'd2); do_rd(2'd2);
        // R8 R9: status-only read-back on all channels, then count+status on 0,1
        live_out = 3'b101;
        do_wr(2'd3, 8'hEE, "R8");
        do_wr(2'd3, 8'hC6, "R8");
        set_live(0, 16'h9999);
        do_rd(2'd0); do_rd(2'd0); do_rd(2'd0);
        do_rd(2'd1); do_rd(2'd1); do_rd(2'd2); do_rd(2'd2);
        do_rd(2'd3);
        // R10: half transfers then reprogram
        do_wr(2'd2, 8'h78, "R4"); do_rd(2'd2);
        do_wr(2'd3, 8'hB0, "R10");
        do_wr(2'd2, 8'h78, "R10"); do_wr(2'd2, 8'h56, "R10");
        do_rd(2'd2); do_rd(2'd2);
        // random mix
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3) do_wr(2'd3, 8'($urandom()), "R8");
            else if (op < 6) do_wr(2'($urandom_range(0, 2)), 8'($urandom()), "R3");
            else if (op < 9) do_rd(2'($urandom_range(0, 3)));
            else begin
                @(negedge clk);
                lc[$urandom_range(0, 2)] = 16'($urandom());
                live_out = 3'($urandom());
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule